// File: doc/BRIEF.md
# Block Address Translation Unit

This unit translates an effective address through a small bank of block translation entries before any segment or page-table lookup is tried. Each entry is a pair of 32-bit words (upper and lower). The unit keeps one bank for instruction fetches and a separate bank for data accesses. A lookup compares the address against every entry in its bank at once. The size of each block comes from a programmable block-length field, which clears low effective-page bits out of the compare. The lowest-indexed entry that matches and is valid for the current privilege wins. From that entry the unit builds the physical address and the read, write and execute rights. It then checks those rights against the access type.

Entries are loaded through a simple word-write port. A lookup is presented as a one-cycle request carrying the address, the access type and a user/supervisor flag. The result comes back on the next cycle: hit, physical address, rights and a permission-fault flag. A compile-time parameter selects the entry layout. The standard layout has per-privilege valid bits and direct protection. The alternate layout has a single valid bit in the lower word and key-based protection.

Top module: `bat_xlate`

## Requirements
- R1: While rst_ni is low and after its release, every entry in both banks is zero and all result outputs are 0; a zeroed entry never hits in either layout.
- R2: A request sampled with req_valid_i high at a rising edge produces rsp_valid_o high after that edge; without a request, rsp_valid_o and every other result output are 0.
- R3: Access type encoding on req_type_i: 0 load, 1 store, 2 fetch, 3 treated as a load. Fetches search the instruction bank (wr_side_i=1), every other type the data bank (wr_side_i=0).
- R4: An entry matches when address bits 31:28 equal upper-word bits 31:28 and address bits 27:17, with the block mask bits cleared, equal upper-word bits 27:17.
- R5: Standard layout (ALT_FMT=0): the upper-word bits 12:2 form the block mask over address bits 27:17. Upper-word bit 1 validates the entry in supervisor mode and bit 0 in user mode (req_user_i=1). Protection comes from lower-word bits 1:0.
- R6: Standard rights: protection 0 grants nothing; any nonzero value grants read and execute; value 2 also grants write.
- R7: Alternate layout (ALT_FMT=1): lower-word bit 6 is the valid bit and lower-word bits 5:0 mask address bits 22:17. The key is upper-word bit 2 in user mode and bit 3 in supervisor mode, and protection comes from upper-word bits 1:0.
- R8: Alternate rights: key 0 gives read and write for protection 0, 1 and 2, and read only for 3. Key 1 gives nothing for 0, read only for 1 and 3, and read and write for 2. Execute is always granted on a hit.
- R9: When several valid entries match, the lowest index is used; higher ones are ignored.
- R10: On a hit, the physical address bits 31:28 are lower-word bits 31:28. Bits 27:17 are the lower-word bits 27:17 ORed with the address bits that the mask selects. Bits 16:12 are the address bits 16:12, and bits 11:0 are zero.
- R11: On a hit, rsp_fault_o is set when the access lacks its right: execute for a fetch, write for a store, read otherwise. Hit and rights are still reported.
- R12: A request that finds no valid matching entry returns hit 0, fault 0, all rights 0 and physical address 0.
- R13: wr_upper_i=1 writes the upper word and 0 the lower word of entry wr_idx_i in bank wr_side_i. A lookup in the same cycle as a write still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry word write strobe |
| wr_side_i | input | 1 | Bank select: 1 instruction, 0 data |
| wr_idx_i | input | IDX_W | Entry index |
| wr_upper_i | input | 1 | 1 upper word, 0 lower word |
| wr_data_i | input | 32 | Word to write |
| req_valid_i | input | 1 | Lookup request |
| req_addr_i | input | 32 | Effective address |
| req_type_i | input | 2 | Access type (0 load, 1 store, 2 fetch) |
| req_user_i | input | 1 | 1 user mode, 0 supervisor |
| rsp_valid_o | output | 1 | Result valid |
| rsp_hit_o | output | 1 | An entry translated the address |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_rd_o | output | 1 | Read right |
| rsp_wr_o | output | 1 | Write right |
| rsp_ex_o | output | 1 | Execute right |
| rsp_fault_o | output | 1 | Hit without the right the access needs |

## Verification
A corrupted entry word, a wrong mask bit or a wrong priority shows up in the first result after the request that touches it. It appears as a wrong hit flag, wrong physical address bits 27:17 or wrong rights, exactly one cycle after the request. A bank mix-up shows as a fetch that hits or misses against the data entries. A stale or early write shows in the lookup that shares its cycle. The bench holds two instances, one per layout. It feeds both the same entry words, so every word is decoded in both ways, and it compares every output of both on every clock.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int ADDR_W = 32;
  localparam int TAG_LO = 28;
  localparam int BLK_LO = 17;
  localparam int BLK_W  = 11;
  localparam int PG_LO  = 12;
  localparam int PG_W   = 5;
  localparam int ALT_BL_W = 6;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } rights_t;

  function automatic rights_t std_rights(input logic [1:0] pp);
    rights_t rt;
    rt.r = (pp != 2'd0);
    rt.x = (pp != 2'd0);
    rt.w = (pp == 2'd2);
    return rt;
  endfunction

  function automatic rights_t key_rights(input logic key, input logic [1:0] pp);
    rights_t rt;
    rt.x = 1'b1;
    if (!key) begin
      rt.r = 1'b1;
      rt.w = (pp != 2'd3);
    end else begin
      rt.r = (pp != 2'd0);
      rt.w = (pp == 2'd2);
    end
    return rt;
  endfunction
endpackage

// File: rtl/bat_regs.sv
module bat_regs #(
  parameter int N_ENT = 4,
  parameter int IDX_W = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic                          wr_side_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic                          wr_upper_i,
  input  logic [bat_pkg::ADDR_W-1:0]    wr_data_i,
  input  logic                          rd_side_i,
  output logic [N_ENT-1:0][bat_pkg::ADDR_W-1:0] up_o,
  output logic [N_ENT-1:0][bat_pkg::ADDR_W-1:0] lo_o
);
  localparam int AW = bat_pkg::ADDR_W;

  logic [1:0][N_ENT-1:0][AW-1:0] up_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= '0;
      lo_q <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < N_ENT; i++) begin
        if (int'(wr_idx_i) == i) begin
          if (wr_upper_i) up_q[wr_side_i][i] <= wr_data_i;
          else            lo_q[wr_side_i][i] <= wr_data_i;
        end
      end
    end
  end

  assign up_o = up_q[rd_side_i];
  assign lo_o = lo_q[rd_side_i];
endmodule

// File: rtl/bat_entry_eval.sv
module bat_entry_eval #(
  parameter bit ALT_FMT = 1'b0
) (
  input  logic [bat_pkg::ADDR_W-1:0] up_i,
  input  logic [bat_pkg::ADDR_W-1:0] lo_i,
  input  logic [bat_pkg::ADDR_W-1:0] ea_i,
  input  logic                       user_i,
  output logic                       hit_o,
  output logic [bat_pkg::ADDR_W-1:0] paddr_o,
  output bat_pkg::rights_t           rights_o
);
  import bat_pkg::*;

  logic [BLK_W-1:0] blk_msk;
  logic             ent_valid;
  logic             tag_eq;
  logic             blk_eq;
  logic [BLK_W-1:0] ea_blk;

  assign ea_blk = ea_i[BLK_LO +: BLK_W];

  generate
    if (ALT_FMT) begin : g_alt
      logic key;
      logic unused_alt;
      assign blk_msk   = {{(BLK_W-ALT_BL_W){1'b0}}, lo_i[ALT_BL_W-1:0]};
      assign ent_valid = lo_i[6];
      assign key       = user_i ? up_i[2] : up_i[3];
      assign rights_o  = key_rights(key, up_i[1:0]);
      assign unused_alt = ^{up_i[BLK_LO-1:4], lo_i[BLK_LO-1:7]};
    end else begin : g_std
      logic unused_std;
      assign blk_msk   = up_i[2 +: BLK_W];
      assign ent_valid = user_i ? up_i[0] : up_i[1];
      assign rights_o  = std_rights(lo_i[1:0]);
      assign unused_std = ^{up_i[BLK_LO-1:2+BLK_W], lo_i[BLK_LO-1:2]};
    end
  endgenerate

  assign tag_eq = (ea_i[ADDR_W-1:TAG_LO] == up_i[ADDR_W-1:TAG_LO]);
  assign blk_eq = ((ea_blk & ~blk_msk) == up_i[BLK_LO +: BLK_W]);
  assign hit_o  = tag_eq && blk_eq && ent_valid;

  assign paddr_o = {lo_i[ADDR_W-1:TAG_LO],
                    (ea_blk & blk_msk) | lo_i[BLK_LO +: BLK_W],
                    ea_i[PG_LO +: PG_W],
                    {PG_LO{1'b0}}};

  logic unused_ea;
  assign unused_ea = ^ea_i[PG_LO-1:0];
endmodule

// File: rtl/bat_first_hit.sv
module bat_first_hit #(
  parameter int N_ENT = 4
) (
  input  logic [N_ENT-1:0]                       hit_i,
  input  logic [N_ENT-1:0][bat_pkg::ADDR_W-1:0]  paddr_i,
  input  bat_pkg::rights_t [N_ENT-1:0]           rights_i,
  output logic                                   any_o,
  output logic [bat_pkg::ADDR_W-1:0]             paddr_o,
  output bat_pkg::rights_t                       rights_o
);
  // descending scan so the lowest index is applied last and wins
  always_comb begin
    any_o    = 1'b0;
    paddr_o  = '0;
    rights_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o    = 1'b1;
        paddr_o  = paddr_i[i];
        rights_o = rights_i[i];
      end
    end
  end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate #(
  parameter int N_ENT   = 4,
  parameter bit ALT_FMT = 1'b0,
  localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_side_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_upper_i,
  input  logic [31:0]      wr_data_i,
  input  logic             req_valid_i,
  input  logic [31:0]      req_addr_i,
  input  logic [1:0]       req_type_i,
  input  logic             req_user_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic [31:0]      rsp_paddr_o,
  output logic             rsp_rd_o,
  output logic             rsp_wr_o,
  output logic             rsp_ex_o,
  output logic             rsp_fault_o
);
  import bat_pkg::*;
  localparam int AW = ADDR_W;

  logic                     rd_side;
  logic [N_ENT-1:0][AW-1:0] ent_up, ent_lo;
  logic [N_ENT-1:0]         ent_hit;
  logic [N_ENT-1:0][AW-1:0] ent_pa;
  rights_t [N_ENT-1:0]      ent_rt;
  logic                     sel_hit;
  logic [AW-1:0]            sel_pa;
  rights_t                  sel_rt;
  logic                     need_ok;
  acc_e                     acc;

  assign acc     = acc_e'(req_type_i);
  assign rd_side = (acc == ACC_FETCH);

  bat_regs #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_side_i (wr_side_i),
    .wr_idx_i  (wr_idx_i),
    .wr_upper_i(wr_upper_i),
    .wr_data_i (wr_data_i),
    .rd_side_i (rd_side),
    .up_o      (ent_up),
    .lo_o      (ent_lo)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    bat_entry_eval #(.ALT_FMT(ALT_FMT)) u_eval (
      .up_i    (ent_up[g]),
      .lo_i    (ent_lo[g]),
      .ea_i    (req_addr_i),
      .user_i  (req_user_i),
      .hit_o   (ent_hit[g]),
      .paddr_o (ent_pa[g]),
      .rights_o(ent_rt[g])
    );
  end

  bat_first_hit #(.N_ENT(N_ENT)) u_sel (
    .hit_i   (ent_hit),
    .paddr_i (ent_pa),
    .rights_i(ent_rt),
    .any_o   (sel_hit),
    .paddr_o (sel_pa),
    .rights_o(sel_rt)
  );

  always_comb begin
    unique case (acc)
      ACC_FETCH: need_ok = sel_rt.x;
      ACC_STORE: need_ok = sel_rt.w;
      default:   need_ok = sel_rt.r;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_rd_o    <= 1'b0;
      rsp_wr_o    <= 1'b0;
      rsp_ex_o    <= 1'b0;
      rsp_fault_o <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= req_valid_i && sel_hit;
      rsp_paddr_o <= (req_valid_i && sel_hit) ? sel_pa : '0;
      rsp_rd_o    <= req_valid_i && sel_hit && sel_rt.r;
      rsp_wr_o    <= req_valid_i && sel_hit && sel_rt.w;
      rsp_ex_o    <= req_valid_i && sel_hit && sel_rt.x;
      rsp_fault_o <= req_valid_i && sel_hit && !need_ok;
    end
  end
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [31:0] req_addr_i,
  input logic [1:0]  req_type_i,
  input logic        rsp_valid_o,
  input logic        rsp_hit_o,
  input logic [31:0] rsp_paddr_o,
  input logic        rsp_rd_o,
  input logic        rsp_wr_o,
  input logic        rsp_ex_o,
  input logic        rsp_fault_o
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_hit_o && !rsp_fault_o && rsp_paddr_o == 32'd0));

  // R12
  miss_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |->
      (!rsp_fault_o && !rsp_rd_o && !rsp_wr_o && !rsp_ex_o && rsp_paddr_o == 32'd0));

  // R10
  page_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (!rsp_hit_o ||
      (rsp_paddr_o[16:12] == $past(req_addr_i[16:12]) && rsp_paddr_o[11:0] == 12'd0)));

  // R11
  store_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_type_i == 2'd1) |=> (!rsp_hit_o || (rsp_fault_o == !rsp_wr_o)));

  // R11
  fetch_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_type_i == 2'd2) |=> (!rsp_hit_o || (rsp_fault_o == !rsp_ex_o)));

  // R11
  load_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_type_i[0] == req_type_i[1]) |=> (!rsp_hit_o || (rsp_fault_o == !rsp_rd_o)));

  // R6
  write_needs_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_wr_o |-> (rsp_rd_o && rsp_hit_o));
endmodule

bind bat_xlate bat_xlate_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_addr_i (req_addr_i),
  .req_type_i (req_type_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_hit_o  (rsp_hit_o),
  .rsp_paddr_o(rsp_paddr_o),
  .rsp_rd_o   (rsp_rd_o),
  .rsp_wr_o   (rsp_wr_o),
  .rsp_ex_o   (rsp_ex_o),
  .rsp_fault_o(rsp_fault_o)
);

// File: tb/bat_xlate_tb.sv
`timescale 1ns/1ps
module bat_xlate_tb;
  localparam int N  = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_ni;
  logic          wr_en, wr_side, wr_upper;
  logic [IW-1:0] wr_idx;
  logic [31:0]   wr_data;
  logic          req_valid, req_user;
  logic [31:0]   req_addr;
  logic [1:0]    req_type;

  logic        s_valid, s_hit, s_rd, s_wr, s_ex, s_fault;
  logic [31:0] s_pa;
  logic        a_valid, a_hit, a_rd, a_wr, a_ex, a_fault;
  logic [31:0] a_pa;

  bat_xlate #(.N_ENT(N), .ALT_FMT(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_side_i(wr_side),
    .wr_idx_i(wr_idx), .wr_upper_i(wr_upper), .wr_data_i(wr_data),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_type_i(req_type),
    .req_user_i(req_user), .rsp_valid_o(s_valid), .rsp_hit_o(s_hit),
    .rsp_paddr_o(s_pa), .rsp_rd_o(s_rd), .rsp_wr_o(s_wr), .rsp_ex_o(s_ex),
    .rsp_fault_o(s_fault));

  bat_xlate #(.N_ENT(N), .ALT_FMT(1'b1)) u_dut_alt (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_side_i(wr_side),
    .wr_idx_i(wr_idx), .wr_upper_i(wr_upper), .wr_data_i(wr_data),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_type_i(req_type),
    .req_user_i(req_user), .rsp_valid_o(a_valid), .rsp_hit_o(a_hit),
    .rsp_paddr_o(a_pa), .rsp_rd_o(a_rd), .rsp_wr_o(a_wr), .rsp_ex_o(a_ex),
    .rsp_fault_o(a_fault));

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit [31:0] m_up [2][N];
  bit [31:0] m_lo [2][N];

  // {valid, hit, paddr[31:0], r, w, x, fault}
  function automatic bit [37:0] ref_eval(bit alt, bit [31:0] ea, bit [1:0] ty, bit usr);
    int side = (ty == 2'd2) ? 1 : 0;
    for (int i = 0; i < N; i++) begin
      bit [31:0] up = m_up[side][i];
      bit [31:0] lo = m_lo[side][i];
      bit [31:0] msk;
      bit vld, key, r, w, x, f;
      bit [1:0] pp;
      bit [31:0] pa;
      if (alt) begin
        msk = (lo & 32'h3F) << 17;
        vld = lo[6];
      end else begin
        msk = (up & 32'h1FFC) << 15;
        vld = usr ? up[0] : up[1];
      end
      if (vld && ((ea & 32'hF000_0000) == (up & 32'hF000_0000)) &&
          (((ea & 32'h0FFE_0000) & ~msk) == (up & 32'h0FFE_0000))) begin
        pa = (lo & 32'hF000_0000) | (ea & 32'h0FFE_0000 & msk) |
             (lo & 32'h0FFE_0000) | (ea & 32'h0001_F000);
        if (alt) begin
          pp  = up[1:0];
          key = usr ? up[2] : up[3];
          x   = 1;
          if (!key) begin r = 1; w = (pp != 3); end
          else begin r = (pp != 0); w = (pp == 2); end
        end else begin
          pp = lo[1:0];
          r  = (pp != 0);
          x  = r;
          w  = (pp == 2);
        end
        f = (ty == 2'd2) ? !x : (ty == 2'd1) ? !w : !r;
        return {1'b1, 1'b1, pa, r, w, x, f};
      end
    end
    return {1'b1, 37'd0};
  endfunction

  task automatic check(string tag, bit [37:0] act, bit [37:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%h expected=%h", cur_req, tag, act, exp);
    end
  endtask

  task automatic cyc(bit we, bit ws, int wi, bit wu, bit [31:0] wd,
                     bit rv, bit [31:0] ra, bit [1:0] rt, bit ru);
    bit [37:0] exp_s, exp_a;
    wr_en = we; wr_side = ws; wr_idx = IW'(wi); wr_upper = wu; wr_data = wd;
    req_valid = rv; req_addr = ra; req_type = rt; req_user = ru;
    exp_s = rv ? ref_eval(1'b0, ra, rt, ru) : 38'd0;
    exp_a = rv ? ref_eval(1'b1, ra, rt, ru) : 38'd0;
    if (we && wi < N) begin
      if (wu) m_up[ws][wi] = wd;
      else    m_lo[ws][wi] = wd;
    end
    @(posedge clk);
    @(negedge clk);
    check("std", {s_valid, s_hit, s_pa, s_rd, s_wr, s_ex, s_fault}, exp_s);
    check("alt", {a_valid, a_hit, a_pa, a_rd, a_wr, a_ex, a_fault}, exp_a);
  endtask

  task automatic wr(bit ws, int wi, bit wu, bit [31:0] wd);
    cyc(1, ws, wi, wu, wd, 0, 0, 0, 0);
  endtask

  task automatic rq(bit [31:0] ra, bit [1:0] rt, bit ru);
    cyc(0, 0, 0, 0, 0, 1, ra, rt, ru);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 0;
    wr_en = 0; wr_side = 0; wr_idx = '0; wr_upper = 0; wr_data = '0;
    req_valid = 0; req_addr = '0; req_type = '0; req_user = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("std", {s_valid, s_hit, s_pa, s_rd, s_wr, s_ex, s_fault}, 38'd0);
    check("alt", {a_valid, a_hit, a_pa, a_rd, a_wr, a_ex, a_fault}, 38'd0);
    rst_ni = 1;
    @(negedge clk);
    rq(32'h0000_0000, 2'd0, 0);   // R1 empty banks miss
    rq(32'hF123_4567, 2'd2, 1);
    cur_req = "R2";
    cyc(0, 0, 0, 0, 0, 0, 32'h8000_0000, 2'd0, 0);

    // R13: upper then lower; lookup in same cycle as lower write sees old
    cur_req = "R13";
    wr(0, 0, 1, 32'h8000_0002);
    cyc(1, 0, 0, 0, 32'h1000_0042, 1, 32'h8001_5ABC, 2'd0, 0);
    rq(32'h8001_5ABC, 2'd0, 0);
    cur_req = "R5";
    rq(32'h8001_5ABC, 2'd0, 1);   // user: standard invalid
    rq(32'h8001_5ABC, 2'd1, 0);
    cur_req = "R3";
    rq(32'h8001_5ABC, 2'd2, 0);   // fetch: instruction bank empty
    rq(32'h8001_5ABC, 2'd3, 0);   // type 3 uses data bank
    cur_req = "R12";
    rq(32'h8002_0000, 2'd0, 0);   // outside 128K block
    rq(32'h9001_0000, 2'd0, 0);

    // R4 / R9: larger block overlapping entry 0
    cur_req = "R9";
    wr(0, 1, 1, 32'h8000_1FFF);
    wr(0, 1, 0, 32'h2000_0041);
    rq(32'h8000_0000, 2'd1, 0);
    rq(32'h8000_0000, 2'd1, 1);
    cur_req = "R4";
    rq(32'h8ABC_D000, 2'd0, 0);
    rq(32'h8FFF_F000, 2'd1, 1);
    rq(32'h7FFF_F000, 2'd0, 0);
    cur_req = "R10";
    wr(0, 2, 1, 32'hC020_00FE);   // mask bits 27:17 partial, base bit 21
    wr(0, 2, 0, 32'h5400_003F);
    rq(32'hC03E_A123, 2'd0, 0);
    rq(32'hC022_F000, 2'd0, 1);
    rq(32'hC060_0000, 2'd0, 0);

    // R6 / R7 / R8 / R11: protection sweep on data entry 3 and instruction entry 0
    for (int ky = 0; ky < 4; ky++) begin
      for (int pp = 0; pp < 4; pp++) begin
        cur_req = "R6";
        wr(0, 3, 1, 32'hA000_0003 | (ky << 2) | pp);
        wr(0, 3, 0, 32'h6000_0040 | pp);
        wr(1, 0, 1, 32'hA000_0003 | (ky << 2) | pp);
        wr(1, 0, 0, 32'h6000_0040 | pp);
        for (int us = 0; us < 2; us++) begin
          cur_req = "R8";
          rq(32'hA001_2000, 2'd0, us[0]);
          cur_req = "R11";
          rq(32'hA001_3000, 2'd1, us[0]);
          cur_req = "R7";
          rq(32'hA001_4000, 2'd2, us[0]);
        end
      end
    end

    // random phase over all requirements
    cur_req = "R9";
    for (int k = 0; k < 3000; k++) begin
      bit [31:0] rnd = $urandom;
      bit [31:0] d   = $urandom;
      bit [31:0] ad  = $urandom;
      if (rnd[2:0] == 3'd0) begin
        d[31:28] = {3'b100, d[28]};
        if (rnd[3]) d[27:17] = d[27:17] & {d[16:13], 7'd0};
        cyc(1, rnd[4], int'(rnd[6:5]), rnd[7], d,
            rnd[8], {3'b100, ad[28], ad[27:0] & {rnd[31:21], 17'h1FFFF}},
            rnd[10:9], rnd[11]);
      end else begin
        cyc(0, 0, 0, 0, 0, rnd[8] | rnd[12],
            {3'b100, ad[28], ad[27:0] & {rnd[31:21], 17'h1FFFF}},
            rnd[10:9], rnd[11]);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule